// File: doc/BRIEF.md
# Register-Mapped Serial Port with Two-Stage Bit Clock

This block is a byte-wide asynchronous serial transmitter and receiver. A processor reaches it through a single-cycle read/write port with two 32-bit words. The word at offset 0 holds configuration and status. The word at offset 4 carries data. Every frame is one low start bit, eight data bits sent least significant first, and one high stop bit. There is no parity. The bit period is the system clock divided by a coarse power-of-two step chosen from eight fixed ratios, multiplied by a fine divisor of up to 1024.

Each direction holds one byte. A write to the data word queues one byte for transmission. A read of the data word returns the last received byte together with its valid flag, and that read consumes the byte. Optional request/clear-to-send handshaking throttles both directions. The transmit interrupt is a one-cycle pulse when a frame completes. The receive interrupt is a level that stays high while an unread byte is held.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `uart_txd` is 1, `rts_n` is 0, both interrupt outputs are 0, the word at offset 0 reads 0, and bit 16 of the word at offset 4 reads 0.
- R2: One bit lasts D × (F + 1) clock cycles. F is the fine field in bits 15:6 of offset 0. D is picked by the coarse code in bits 5:3: codes 0 to 7 give D = 2, 4, 8, 64, 128, 1024, 2048 and 4096.
- R3: Writing offset 4 while the unit is idle sends bits 7:0 of the write data. The frame is a 0 start bit, then the eight data bits least significant first, then a 1 stop bit.
- R4: Bit 31 of offset 0 reads 1 from the cycle after a data write until the stop bit ends. Frame completion gives exactly one single-cycle pulse on `irq_tx` when bit 25 or bit 26 of offset 0 is set.
- R5: While bit 0 of offset 0 is 0, writes to offset 4 are dropped, `uart_txd` stays 1, bit 31 reads 0, and incoming frames are not received. Setting bit 0 again restores normal operation.
- R6: A read of offset 4 returns the received byte in bits 7:0 and a valid flag in bit 16, then clears the flag. Bits 16, 17 and 18 of offset 0 all mirror the valid flag.
- R7: A received frame whose stop bit samples 0 is discarded and does not set the valid flag.
- R8: Bit 30 of offset 0 sets when a byte completes while the previous byte is still unread. It clears on a read of offset 4.
- R9: When bit 2 of offset 0 is set, `rts_n` is 1 while a received byte is unread, and no frame starts while `cts_n` is 1. A held frame starts once `cts_n` returns to 0.
- R10: `irq_rx` is 1 exactly while a received byte is unread and at least one of bits 22, 23 or 24 of offset 0 is set.
- R11: Bits 15:0 and 26:22 of offset 0 read back as last written. Write data in bits 21:16 and 31:27 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address; 0 selects configuration/status, 4 selects data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of offset 4 consumes the received byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid in the same cycle |
| uart_txd | output | 1 | Serial output, idle high |
| uart_rxd | input | 1 | Serial input, idle high |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq_tx | output | 1 | Transmit-complete pulse |
| irq_rx | output | 1 | Receive-data-waiting level |

## Verification
The bench builds the block with its default fine-field width of 10 bits. It then sets small divisor fields at run time, so most frames finish in 80 to 120 cycles. Three coarse/fine pairs give bit periods of 8, 12 and 64 cycles. These bring the coarse table, the minus-one fine field, the receiver's mid-bit sampling and the handshake hold-off within reach of a short run. The largest coarse ratios are not exercised, because each bit at those ratios would take thousands of cycles.

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int BAUD_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        uart_txd,
  input  logic        uart_rxd,
  input  logic        cts_n,
  output logic        rts_n,
  output logic        irq_tx,
  output logic        irq_rx
);
  localparam int CNT_W = BAUD_W + 13;

  logic              en, sim, fc;
  logic [2:0]        prsc;
  logic [BAUD_W-1:0] baud;
  logic [4:0]        ien;

  wire sel_ctrl = (bus_addr == 3'd0);
  wire sel_data = (bus_addr == 3'd4);
  wire wr_ctrl  = bus_we & sel_ctrl;
  wire wr_data  = bus_we & sel_data;
  wire rd_data  = bus_re & sel_data;
  wire unused_wbits = ^{bus_wdata[31:27], bus_wdata[21:16]};

  logic [3:0] shamt;
  always_comb begin
    case (prsc)
      3'd0:    shamt = 4'd1;
      3'd1:    shamt = 4'd2;
      3'd2:    shamt = 4'd3;
      3'd3:    shamt = 4'd6;
      3'd4:    shamt = 4'd7;
      3'd5:    shamt = 4'd10;
      3'd6:    shamt = 4'd11;
      default: shamt = 4'd12;
    endcase
  end

  wire [CNT_W-1:0] period = (CNT_W'(baud) + CNT_W'(1)) << shamt;
  wire [CNT_W-1:0] half   = period >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; sim <= 1'b0; fc <= 1'b0;
      prsc <= '0; baud <= '0; ien <= '0;
    end else if (wr_ctrl) begin
      en   <= bus_wdata[0];
      sim  <= bus_wdata[1];
      fc   <= bus_wdata[2];
      prsc <= bus_wdata[5:3];
      baud <= bus_wdata[6 +: BAUD_W];
      ien  <= bus_wdata[26:22];
    end
  end

  logic [1:0] cts_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_s <= 2'b11;
    else        cts_s <= {cts_s[0], cts_n};
  end

  logic             tx_pend, tx_act;
  logic [7:0]       tx_buf;
  logic [9:0]       tx_sh;
  logic [3:0]       tx_bit;
  logic [CNT_W-1:0] tx_cnt;
  wire tx_busy = tx_pend | tx_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0; tx_act <= 1'b0; tx_buf <= '0;
      tx_sh <= '1; tx_bit <= '0; tx_cnt <= '0; irq_tx <= 1'b0;
    end else if (!en) begin
      tx_pend <= 1'b0; tx_act <= 1'b0; irq_tx <= 1'b0;
    end else begin
      irq_tx <= 1'b0;
      if (wr_data && !tx_busy) begin
        tx_pend <= 1'b1;
        tx_buf  <= bus_wdata[7:0];
      end
      if (tx_pend && !tx_act && !(fc && cts_s[1])) begin
        tx_pend <= 1'b0;
        tx_act  <= 1'b1;
        tx_sh   <= {1'b1, tx_buf, 1'b0};
        tx_bit  <= '0;
        tx_cnt  <= period - CNT_W'(1);
      end else if (tx_act) begin
        if (tx_cnt == '0) begin
          if (tx_bit == 4'd9) begin
            tx_act <= 1'b0;
            irq_tx <= ien[3] | ien[4];
          end else begin
            tx_bit <= tx_bit + 4'd1;
            tx_sh  <= {1'b1, tx_sh[9:1]};
            tx_cnt <= period - CNT_W'(1);
          end
        end else begin
          tx_cnt <= tx_cnt - CNT_W'(1);
        end
      end
    end
  end

  assign uart_txd = ~tx_act | tx_sh[0];

  logic [1:0]       rx_s;
  logic             rx_prev, rx_act, rx_valid, rx_ovr;
  logic [3:0]       rx_bit;
  logic [CNT_W-1:0] rx_cnt;
  logic [7:0]       rx_sh, rx_data;
  wire rx_in = rx_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s <= 2'b11; rx_prev <= 1'b1; rx_act <= 1'b0;
      rx_valid <= 1'b0; rx_ovr <= 1'b0; rx_bit <= '0;
      rx_cnt <= '0; rx_sh <= '0; rx_data <= '0;
    end else begin
      rx_s    <= {rx_s[0], uart_rxd};
      rx_prev <= rx_in;
      if (rd_data) begin
        rx_valid <= 1'b0;
        rx_ovr   <= 1'b0;
      end
      if (!en) begin
        rx_act <= 1'b0;
      end else if (!rx_act) begin
        if (rx_prev && !rx_in) begin
          rx_act <= 1'b1;
          rx_bit <= '0;
          rx_cnt <= half - CNT_W'(1);
        end
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - CNT_W'(1);
      end else begin
        case (rx_bit)
          4'd0: begin
            if (rx_in) rx_act <= 1'b0;
            else begin
              rx_bit <= 4'd1;
              rx_cnt <= period - CNT_W'(1);
            end
          end
          4'd9: begin
            rx_act <= 1'b0;
            if (rx_in) begin
              rx_data  <= rx_sh;
              rx_valid <= 1'b1;
              if (rx_valid && !rd_data) rx_ovr <= 1'b1;
            end
          end
          default: begin
            rx_sh  <= {rx_in, rx_sh[7:1]};
            rx_bit <= rx_bit + 4'd1;
            rx_cnt <= period - CNT_W'(1);
          end
        endcase
      end
    end
  end

  assign rts_n  = fc & rx_valid;
  assign irq_rx = rx_valid & (|ien[2:0]);

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = en;
    ctrl_word[1] = sim;
    ctrl_word[2] = fc;
    ctrl_word[5:3] = prsc;
    ctrl_word[6 +: BAUD_W] = baud;
    ctrl_word[18:16] = {3{rx_valid}};
    ctrl_word[21:19] = {3{tx_busy}};
    ctrl_word[26:22] = ien;
    ctrl_word[30] = rx_ovr;
    ctrl_word[31] = tx_busy;
  end

  assign bus_rdata = sel_ctrl ? ctrl_word :
                     sel_data ? {15'd0, rx_valid, 8'd0, rx_data} : 32'd0;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_act) |-> !uart_txd); // R3
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && en && !tx_busy) |=> tx_busy); // R4
  AST_IRQ_TX_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx); // R4
  AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> uart_txd); // R5
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_act) |=> !rx_valid); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid)); // R8
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fc && cts_s[1] && !tx_act) |=> !tx_act); // R9
endmodule

// File: tb/tb_uart_mmio.sv
module tb_uart_mmio;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bus_we, bus_re, uart_rxd, cts_n;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        uart_txd, rts_n, irq_tx, irq_rx;

  uart_mmio dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart_txd(uart_txd), .uart_rxd(uart_rxd), .cts_n(cts_n), .rts_n(rts_n),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  int errors = 0;
  int checks = 0;
  int bit_p = 2;
  int irq_cnt = 0;
  logic irq_prev = 1'b0;
  logic [7:0] txq[$];
  int div_tab[8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  function automatic logic [31:0] cfg_word(input bit en, input bit fc, input int prsc,
                                           input int baud, input logic [4:0] ien);
    return {5'd0, ien, 6'd0, 10'(baud), 3'(prsc), fc, 1'b0, en};
  endfunction

  task automatic cfg(input bit en, input bit fc, input int prsc, input int baud,
                     input logic [4:0] ien);
    wr(3'd0, cfg_word(en, fc, prsc, baud, ien));
    bit_p = div_tab[prsc] * (baud + 1);
  endtask

  task automatic send_tx(input logic [7:0] b);
    txq.push_back(b);
    wr(3'd4, {24'd0, b});
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, d);
      if (!d[31]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    uart_rxd = 1'b0;
    repeat (bit_p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rxd = b[i];
      repeat (bit_p) @(negedge clk);
    end
    uart_rxd = stop;
    repeat (bit_p) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && irq_tx) irq_cnt++;
    if (rst_n && irq_tx && irq_prev) chk("R4 pulse width", 2, 1);
    irq_prev <= irq_tx;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] exp_b;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && uart_txd === 1'b0) begin
        repeat (bit_p / 2 - 1) @(negedge clk);
        chk("R3 start bit", uart_txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_p) @(negedge clk);
          got[i] = uart_txd;
        end
        repeat (bit_p) @(negedge clk);
        chk("R3 stop bit", uart_txd, 1);
        if (txq.size() == 0) chk("R3 R5 unexpected frame", got, 0);
        else begin
          exp_b = txq.pop_front();
          chk("R2 R3 frame data", got, exp_b);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit seen_low;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    uart_rxd = 1'b1; cts_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 txd", uart_txd, 1);
    chk("R1 rts_n", rts_n, 0);
    chk("R1 irqs", {irq_tx, irq_rx}, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd4, d); chk("R1 valid", d[16], 0);

    wr(3'd0, cfg_word(1, 0, 0, 3, 5'b01000) | 32'h803F_0000);
    bit_p = 8;
    rd(3'd0, d); chk("R11 readback", d, cfg_word(1, 0, 0, 3, 5'b01000));

    send_tx(8'hA5);
    rd(3'd0, d); chk("R4 busy", d[31], 1);
    wait_idle();
    chk("R4 irq pulses", irq_cnt, 1);

    cfg(1, 0, 1, 2, 5'b10000);
    send_tx(8'h3C); wait_idle();
    cfg(1, 0, 3, 0, 5'b10000);
    send_tx(8'h01); wait_idle();
    chk("R2 R4 irq pulses", irq_cnt, 3);

    cfg(1, 0, 0, 3, 5'b00001);
    rx_frame(8'h5A, 1'b1);
    chk("R10 irq_rx set", irq_rx, 1);
    rd(3'd0, d); chk("R6 status levels", d[18:16], 3'b111);
    rd(3'd4, d); chk("R6 data", d, 32'h0001_005A);
    rd(3'd4, d); chk("R6 cleared", d[16], 0);
    chk("R10 irq_rx clear", irq_rx, 0);

    rx_frame(8'h77, 1'b0);
    rd(3'd4, d); chk("R7 framing discard", d[16], 0);

    rx_frame(8'h11, 1'b1);
    rx_frame(8'h22, 1'b1);
    rd(3'd0, d); chk("R8 overrun set", d[30], 1);
    rd(3'd4, d); chk("R8 newest byte", d, 32'h0001_0022);
    rd(3'd0, d); chk("R8 overrun clear", d[30], 0);

    cfg(1, 1, 0, 3, 5'b00000);
    rx_frame(8'h44, 1'b1);
    chk("R9 rts_n high", rts_n, 1);
    rd(3'd4, d);
    chk("R9 rts_n low", rts_n, 0);
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    send_tx(8'h99);
    seen_low = 0;
    for (int i = 0; i < 4 * bit_p; i++) begin
      @(negedge clk);
      if (!uart_txd) seen_low = 1;
    end
    chk("R9 cts hold", seen_low, 0);
    rd(3'd0, d); chk("R9 held busy", d[31], 1);
    cts_n = 1'b0;
    wait_idle();
    chk("R9 held frame sent", txq.size(), 0);

    cfg(0, 0, 0, 3, 5'b00000);
    wr(3'd4, 32'h55);
    seen_low = 0;
    for (int i = 0; i < 20 * bit_p; i++) begin
      @(negedge clk);
      if (!uart_txd) seen_low = 1;
    end
    chk("R5 disabled line idle", seen_low, 0);
    rd(3'd0, d); chk("R5 disabled busy", d[31], 0);
    rx_frame(8'h66, 1'b1);
    rd(3'd4, d); chk("R5 disabled rx", d[16], 0);

    cfg(1, 0, 0, 3, 5'b00000);
    send_tx(8'h81);
    wait_idle();
    chk("R5 resume queue drained", txq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule